// File: doc/BRIEF.md
# Binary FSK Symbol Mapper

This block turns a stream of 32-bit data words into a continuous-phase two-tone sine waveform for a DAC. Each word arriving on the stream slave port is captured and sent one bit at a time, starting with bit 0. Every bit is sent as exactly one full sine cycle. A zero bit uses a slow tone and a one bit uses a fast tone, so a one plays at roughly twice the frequency of a zero.

The waveform comes from a one-cycle sine table with one entry per degree. A degree counter steps through the table one degree at a time. A dwell counter makes each table entry last for a set number of output beats, and that count is what sets the tone frequency. A new bit always starts at degree 0, so the phase is continuous when the tone changes.

Samples leave on a stream master port, one signed sample per beat. When the downstream side stalls, all progress stops. A side output marks the beats of the last bit of each word.

Top module: `fsk_symbol_mapper`

## Requirements
- R1: The sample for degree d (0..359) is computed with A = AMP (default 0x6660) and h(x) = floor(A*4x(180-x) / (40500 - x(180-x))). For d below 180 the sample is h(d); from 180 up it is -h(d-180), in two's complement. So degree 90 gives +A, degree 270 gives -A, and degrees 0 and 180 give 0.
- R2: Within a bit, degree d is presented on exactly P handshaked beats (m_axis_tvalid and m_axis_tready both high), for d = 0, 1, ..., 359 in that order. After degree 359 the degree returns to 0.
- R3: P is ZERO_DWELL (default 2) for a 0 bit and ONE_DWELL (default 1) for a 1 bit. A bit therefore lasts 360*P handshaked beats.
- R4: Each bit is exactly one full sine cycle and begins at degree 0. The next bit starts on the beat after the last beat of degree 359 of the current bit.
- R5: The bits of a word are sent least significant first, from bit 0 up to bit 31.
- R6: word_tail is high on every beat of bit 31 of the current word. It is low on the beats of bits 0 to 30.
- R7: A slave beat completes whenever s_axis_tvalid and s_axis_tready are both high. It is taken as a word only if s_axis_tkeep is 4'hF. A beat with any tkeep bit clear is discarded: it produces no samples, its tlast is ignored, and s_axis_tready stays high. s_axis_tready is low while a word is being sent.
- R8: m_axis_tlast is high only on the final beat of a word that carried s_axis_tlast.
- R9: If the finished word carried tlast, s_axis_tready is low in the cycle after its final beat and rises in the cycle after that. If the word did not carry tlast, s_axis_tready is high in the cycle right after the final beat.
- R10: While m_axis_tvalid is high and m_axis_tready is low, m_axis_tdata, m_axis_tlast and word_tail hold their values. No sample is dropped or repeated.
- R11: While rst_n is low (synchronous, active low), m_axis_tvalid, s_axis_tready, m_axis_tlast and word_tail are 0, and m_axis_tdata shows degree 0, which is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_axis_tdata | input | 32 | Word to be sent |
| s_axis_tkeep | input | 4 | Byte enables; all four must be set for the word to be used |
| s_axis_tlast | input | 1 | Marks the last word of a packet |
| s_axis_tvalid | input | 1 | Slave beat valid |
| s_axis_tready | output | 1 | Slave beat ready |
| m_axis_tdata | output | 16 | Signed sine sample |
| m_axis_tlast | output | 1 | Final beat of a word that carried tlast |
| m_axis_tvalid | output | 1 | Master beat valid |
| m_axis_tready | input | 1 | Master beat ready |
| word_tail | output | 1 | High while bit 31 of the current word is sent |

## Verification
The tests use four kinds of input. An all-ones word shows the fast dwell on its own and the full positive and negative peaks. A mixed bit pattern sent with a random downstream stall shows bit order, the switch between dwell periods and that no beat is lost during a stall. A beat with a partial tkeep followed by a good word shows that the bad beat is dropped without adding any output. Back-to-back words, one with tlast and one without, show where m_axis_tlast is placed and how s_axis_tready recovers in each case. Every handshaked beat is compared with a model of the table formula that the bench keeps itself.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  localparam int DEG_N = 360;
  localparam int HALF_DEG = 180;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SEND} ser_state_e;

  // One half-wave of the tone, integer rational approximation of sine.
  function automatic longint half_wave(input longint x, input longint amp);
    longint s;
    s = x * (HALF_DEG - x);
    return (amp * 4 * s) / (40500 - s);
  endfunction

  function automatic longint sine_deg(input longint d, input longint amp);
    if (d < HALF_DEG) return half_wave(d, amp);
    return -half_wave(d - HALF_DEG, amp);
  endfunction
endpackage

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom #(
  parameter int SAMPLE_W = 16,
  parameter int AMP      = 26208,
  parameter int PHASE_W  = 9
) (
  input  logic [PHASE_W-1:0]         phase,
  output logic signed [SAMPLE_W-1:0] sample
);
  logic signed [SAMPLE_W-1:0] tbl [fsk_pkg::DEG_N];

  for (genvar g = 0; g < fsk_pkg::DEG_N; g++) begin : g_tbl
    assign tbl[g] = SAMPLE_W'(fsk_pkg::sine_deg(g, AMP));
  end

  assign sample = (int'(phase) < fsk_pkg::DEG_N) ? tbl[phase] : '0;
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen #(
  parameter int ZERO_DWELL = 2,
  parameter int ONE_DWELL  = 1,
  parameter int PHASE_W    = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_val,
  input  logic               beat_fire,
  output logic [PHASE_W-1:0] phase,
  output logic               last_beat,
  output logic               cycle_end
);
  localparam int MAX_DWELL = (ZERO_DWELL > ONE_DWELL) ? ZERO_DWELL : ONE_DWELL;
  localparam int DWELL_W   = (MAX_DWELL < 2) ? 1 : $clog2(MAX_DWELL);
  localparam logic [PHASE_W-1:0] LAST_DEG = PHASE_W'(fsk_pkg::DEG_N - 1);

  logic [DWELL_W-1:0] dwell;
  logic [DWELL_W-1:0] period_m1;
  logic               dwell_last;
  logic               step;

  assign period_m1  = bit_val ? DWELL_W'(ONE_DWELL - 1) : DWELL_W'(ZERO_DWELL - 1);
  assign dwell_last = (dwell == period_m1);
  assign step       = beat_fire && dwell_last;
  assign last_beat  = dwell_last && (phase == LAST_DEG);
  assign cycle_end  = beat_fire && last_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      dwell <= '0;
    end else if (beat_fire) begin
      if (dwell_last) begin
        dwell <= '0;
        phase <= (phase == LAST_DEG) ? '0 : phase + 1'b1;
      end else begin
        dwell <= dwell + 1'b1;
      end
    end
  end

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_fire |=> $stable(phase) && $stable(dwell));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> phase == '0 && dwell == '0);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase != LAST_DEG) |=> phase == $past(phase) + 1'b1);
  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST_DEG);
endmodule

// File: rtl/fsk_bit_serializer.sv
module fsk_bit_serializer #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_keep_full,
  input  logic              s_last,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              cycle_end,
  output logic              sending,
  output logic              cur_bit,
  output logic              tail_bit,
  output logic              word_tlast
);
  import fsk_pkg::*;
  localparam int BIDX_W = $clog2(WORD_W);

  ser_state_e        state;
  logic [WORD_W-1:0] shreg;
  logic [BIDX_W-1:0] bidx;
  logic              take;
  logic              word_done;

  assign s_ready   = (state == ST_FETCH);
  assign sending   = (state == ST_SEND);
  assign take      = s_ready && s_valid && s_keep_full;
  assign cur_bit   = shreg[0];
  assign tail_bit  = (bidx == BIDX_W'(WORD_W - 1));
  assign word_done = sending && cycle_end && tail_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      bidx       <= '0;
      word_tlast <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:  state <= ST_FETCH;
        ST_FETCH: if (take) begin
          shreg      <= s_data;
          bidx       <= '0;
          word_tlast <= s_last;
          state      <= ST_SEND;
        end
        ST_SEND: if (cycle_end) begin
          if (tail_bit) state <= word_tlast ? ST_IDLE : ST_FETCH;
          else begin
            shreg <= shreg >> 1;
            bidx  <= bidx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && word_tlast) |=> !s_ready ##1 s_ready);
  p_end_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !word_tlast) |=> s_ready);
  p_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid && !s_keep_full) |=> s_ready);
  p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && !cycle_end) |=> $stable(cur_bit) && $stable(bidx));
endmodule

// File: rtl/fsk_symbol_mapper.sv
module fsk_symbol_mapper #(
  parameter int ZERO_DWELL = 2,
  parameter int ONE_DWELL  = 1,
  parameter int AMP        = 26208
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] s_axis_tdata,
  input  logic [3:0]  s_axis_tkeep,
  input  logic        s_axis_tlast,
  input  logic        s_axis_tvalid,
  output logic        s_axis_tready,
  output logic [15:0] m_axis_tdata,
  output logic        m_axis_tlast,
  output logic        m_axis_tvalid,
  input  logic        m_axis_tready,
  output logic        word_tail
);
  localparam int WORD_W   = 32;
  localparam int SAMPLE_W = 16;
  localparam int PHASE_W  = $clog2(fsk_pkg::DEG_N);

  logic               sending, cur_bit, tail_bit, word_tlast;
  logic               beat_fire, last_beat, cycle_end;
  logic [PHASE_W-1:0] phase;
  logic signed [SAMPLE_W-1:0] sample;

  assign beat_fire = sending && m_axis_tready;

  fsk_bit_serializer #(.WORD_W(WORD_W)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .s_data(s_axis_tdata), .s_keep_full(&s_axis_tkeep),
    .s_last(s_axis_tlast), .s_valid(s_axis_tvalid), .s_ready(s_axis_tready),
    .cycle_end(cycle_end), .sending(sending), .cur_bit(cur_bit),
    .tail_bit(tail_bit), .word_tlast(word_tlast)
  );

  fsk_tone_gen #(.ZERO_DWELL(ZERO_DWELL), .ONE_DWELL(ONE_DWELL), .PHASE_W(PHASE_W)) u_tone (
    .clk(clk), .rst_n(rst_n), .bit_val(cur_bit), .beat_fire(beat_fire),
    .phase(phase), .last_beat(last_beat), .cycle_end(cycle_end)
  );

  fsk_sine_rom #(.SAMPLE_W(SAMPLE_W), .AMP(AMP), .PHASE_W(PHASE_W)) u_rom (
    .phase(phase), .sample(sample)
  );

  assign m_axis_tvalid = sending;
  assign m_axis_tdata  = sample;
  assign word_tail     = sending && tail_bit;
  assign m_axis_tlast  = sending && tail_bit && word_tlast && last_beat;

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_axis_tvalid && !m_axis_tready) |=> m_axis_tvalid && $stable(m_axis_tdata)
      && $stable(m_axis_tlast) && $stable(word_tail));
  p_tlast_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_axis_tlast |-> word_tail);
  p_ready_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_axis_tready |-> !m_axis_tvalid);
endmodule

// File: tb/tb_fsk_symbol_mapper.sv
module tb_fsk_symbol_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int P0 = 2;
  localparam int P1 = 1;
  localparam int AMPL = 26208;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] s_axis_tdata = '0;
  logic [3:0]  s_axis_tkeep = '0;
  logic        s_axis_tlast = 0;
  logic        s_axis_tvalid = 0;
  logic        s_axis_tready;
  logic [15:0] m_axis_tdata;
  logic        m_axis_tlast;
  logic        m_axis_tvalid;
  logic        m_axis_tready = 1;
  logic        word_tail;

  fsk_symbol_mapper #(.ZERO_DWELL(P0), .ONE_DWELL(P1), .AMP(AMPL)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  typedef struct packed {logic b; logic lb; logic tl;} exp_t;
  exp_t exp_q[$];
  int md = 0, mr = 0, beats = 0, mism = 0, act0 = 0, exp0 = 0;
  int smax = 0, smin = 0, ready_bad = 0, extra = 0;
  logic pend = 0, pend_exp = 0;
  logic stall_en = 0;
  logic [7:0] lfsr = 8'hA5;

  function automatic int ref_sine(int d);
    real x, s;
    int sign;
    sign = 1;
    x = real'(d);
    if (d >= 180) begin x = real'(d - 180); sign = -1; end
    s = x * (180.0 - x);
    return sign * int'($floor(real'(AMPL) * 4.0 * s / (40500.0 - s)));
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Downstream ready pattern, changed just after each rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      m_axis_tready = stall_en ? (lfsr[1:0] != 2'b00) : 1'b1;
    end
  end

  // Beat monitor against the bench's own stream model
  always @(negedge clk) begin
    if (pend) begin
      if (s_axis_tready !== pend_exp) ready_bad++;
      pend = 0;
    end
    if (rst_n && m_axis_tvalid && m_axis_tready) begin
      if (exp_q.size() == 0) extra++;
      else begin
        exp_t e;
        int per, ed;
        logic fin, bad;
        e = exp_q[0];
        per = e.b ? P1 : P0;
        ed = ref_sine(md);
        fin = (md == 359) && (mr == per - 1);
        bad = (m_axis_tdata !== 16'(ed)) || (word_tail !== e.lb)
              || (m_axis_tlast !== (e.tl && e.lb && fin));
        if (bad) begin
          if (mism == 0) begin act0 = int'($signed(m_axis_tdata)); exp0 = ed; end
          mism++;
        end
        if (int'($signed(m_axis_tdata)) > smax) smax = int'($signed(m_axis_tdata));
        if (int'($signed(m_axis_tdata)) < smin) smin = int'($signed(m_axis_tdata));
        beats++;
        if (mr == per - 1) begin
          mr = 0;
          if (md == 359) begin
            md = 0;
            if (e.lb) begin pend = 1; pend_exp = !e.tl; end
            void'(exp_q.pop_front());
          end else md++;
        end else mr++;
      end
    end
  end

  task automatic clear_stats();
    beats = 0; mism = 0; smax = 0; smin = 0; ready_bad = 0; extra = 0;
  endtask

  function automatic int word_beats(logic [31:0] w);
    int n = 0;
    for (int i = 0; i < 32; i++) n += 360 * (w[i] ? P1 : P0);
    return n;
  endfunction

  task automatic send_word(input logic [31:0] w, input logic [3:0] k, input logic last);
    @(negedge clk);
    s_axis_tdata = w; s_axis_tkeep = k; s_axis_tlast = last; s_axis_tvalid = 1;
    while (!s_axis_tready) @(negedge clk);
    if (k == 4'hF)
      for (int i = 0; i < 32; i++) exp_q.push_back('{b: w[i], lb: (i == 31), tl: last});
    @(negedge clk);
    s_axis_tvalid = 0;
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(m_axis_tvalid === 0, "R11 tvalid in reset", int'(m_axis_tvalid), 0);
    check(s_axis_tready === 0, "R11 tready in reset", int'(s_axis_tready), 0);
    check(m_axis_tdata === 16'h0, "R11 sample at degree 0", int'(m_axis_tdata), 0);
    check(m_axis_tlast === 0 && word_tail === 0, "R11 tlast/word_tail", int'(m_axis_tlast), 0);
    rst_n = 1;
  endtask

  task automatic t_all_ones();
    clear_stats();
    stall_en = 0;
    send_word(32'hFFFF_FFFF, 4'hF, 1'b0);
    drain();
    check(mism == 0, "R1 R2 R4 R6 sample stream ones", act0, exp0);
    check(beats == word_beats(32'hFFFF_FFFF), "R3 one-bit duration", beats, word_beats(32'hFFFF_FFFF));
    check(smax == AMPL, "R1 positive peak", smax, AMPL);
    check(smin == -AMPL, "R1 negative peak", smin, -AMPL);
  endtask

  task automatic t_pattern_stall();
    clear_stats();
    stall_en = 1;
    send_word(32'hA5C3_0F1E, 4'hF, 1'b0);
    drain();
    stall_en = 0;
    check(mism == 0, "R5 R10 lsb-first stream under stall", act0, exp0);
    check(beats == word_beats(32'hA5C3_0F1E), "R3 R10 beat count under stall", beats, word_beats(32'hA5C3_0F1E));
    check(extra == 0, "R10 no repeated beats", extra, 0);
  endtask

  task automatic t_partial_keep();
    clear_stats();
    send_word(32'hFFFF_FFFF, 4'h7, 1'b1);
    check(s_axis_tready === 1 && m_axis_tvalid === 0, "R7 partial beat dropped",
          int'(s_axis_tready), 1);
    send_word(32'h0000_FFFF, 4'hF, 1'b0);
    drain();
    check(mism == 0, "R7 stream after discard", act0, exp0);
    check(beats == word_beats(32'h0000_FFFF), "R7 no samples from dropped beat", beats, word_beats(32'h0000_FFFF));
  endtask

  task automatic t_tlast();
    clear_stats();
    send_word(32'h1234_5678, 4'hF, 1'b1);
    send_word(32'h8765_4321, 4'hF, 1'b0);
    drain();
    check(mism == 0, "R8 R6 tlast placement", act0, exp0);
    check(ready_bad == 0, "R9 tready after word end", ready_bad, 0);
    check(beats == word_beats(32'h1234_5678) + word_beats(32'h8765_4321),
          "R4 back-to-back bits", beats, word_beats(32'h1234_5678) + word_beats(32'h8765_4321));
    check(extra == 0, "R2 no stray beats", extra, 0);
  endtask

  initial begin
    t_reset();
    t_all_ones();
    t_pattern_stall();
    t_partial_keep();
    t_tlast();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule